// File: doc/BRIEF.md
# Inter-Thread FIFO Storage Cell

This block is one storage cell that hardware threads use to pass 32-bit words to each other. A single request port carries a view code, the issuing thread number, a write strobe and write data. The cell keeps a small ring queue and a status tag. The view code picks how an access treats the queue:

- The synchronized view suspends the thread when the access cannot proceed.
- The try view never suspends; an access that cannot proceed fails silently.
- The bypass view peeks at the queue or patches it without changing its state.
- The control view reads the status tag or clears the queue.

A suspended access is parked inside the cell, one slot per thread, and the thread's ready bit goes low. The access finishes later, on an idle port cycle, once another thread has changed the queue so that it can go ahead. Each completed access returns one response, one clock after it finishes, carrying the thread number and the read data.

Top module: `itc_fifo_cell`

## Requirements
- R1: View code 0 is the synchronized view. A store pushes `req_wdata` and a load pops the oldest entry and returns it, so words come out in the order they were stored.
- R2: In view 0, a load from an empty queue or a store to a full queue parks the access. It gives no response, and `thr_ready[tid]` is low from the next cycle on.
- R3: On a cycle with `req_valid` low, the lowest-numbered parked thread whose access can now proceed completes it: a store pushes its word and a load pops. Its ready bit rises in the same cycle as its response. A parked access cannot complete while the port is busy.
- R4: View code 1 is the try view. A store to a full queue is dropped, and a load from an empty queue returns 0. No access in this view is ever parked.
- R5: View code 2 is the bypass view. A load returns the oldest entry without removing it, or returns 0 when the queue is empty.
- R6: In view 2, a store replaces the newest entry when the queue holds data, and has no effect when the queue is empty. The occupancy never changes in this view.
- R7: View code 3 is the control view. A load returns the tag: bit 0 is Empty, bit 1 is Full, bit 2 is the cell-type bit and always reads 1, bits 12:8 hold the occupancy, and all other bits read 0.
- R8: A control-view store with bit 0 of the data set to 1 empties the queue. All other bits of that store, including the type and Full positions, are ignored.
- R9: After reset the queue is empty, every `thr_ready` bit is 1 and `rsp_valid` is 0.
- R10: Every access that is not parked produces exactly one response in the next cycle, tagged with its thread number. A store's response data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An access is presented this cycle |
| req_view | input | 2 | 0 sync, 1 try, 2 bypass, 3 control |
| req_tid | input | TID_W | Issuing thread number |
| req_we | input | 1 | 1 store, 0 load |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | A response is presented |
| rsp_tid | output | TID_W | Thread the response belongs to |
| rsp_rdata | output | 32 | Load data, 0 for stores |
| thr_ready | output | NTHREADS | Per-thread ready; low while that thread is parked |

## Verification
The assertions assume that a thread whose ready bit is low presents no request, because its only slot is already occupied. The stimulus draws each random request only from threads the bench model shows as ready. When every thread ends up parked and nothing can proceed, the stimulus applies a reset instead of a request. Idle cycles are mixed in at random so that parked accesses get a chance to complete.

// File: rtl/itc_cell_pkg.sv
package itc_cell_pkg;

    localparam int CELL_DW   = 32;
    localparam int TAG_CNT_W = 5;

    typedef enum logic [1:0] {
        VIEW_SYNC   = 2'd0,
        VIEW_TRY    = 2'd1,
        VIEW_BYPASS = 2'd2,
        VIEW_CTRL   = 2'd3
    } view_e;

    // Status word returned by a control-view load
    typedef struct packed {
        logic [18:0]          rsvd_hi;
        logic [TAG_CNT_W-1:0] occ;
        logic [4:0]           rsvd_lo;
        logic                 is_fifo;
        logic                 full;
        logic                 empty;
    } tag_t;

    localparam int FLUSH_BIT = 0;

    function automatic tag_t make_tag(input logic [TAG_CNT_W-1:0] occ,
                                      input logic full, input logic empty);
        tag_t t;
        t         = '0;
        t.occ     = occ;
        t.is_fifo = 1'b1;
        t.full    = full;
        t.empty   = empty;
        return t;
    endfunction

endpackage

// File: rtl/itc_ring.sv
module itc_ring #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          ovw,
    input  logic          flush,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] rd_ptr, wr_ptr;
    logic [AW-1:0] newest;

    assign newest = wr_ptr[AW-1:0] - AW'(1);
    assign count  = wr_ptr - rd_ptr;
    assign head   = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else if (flush) begin
            rd_ptr <= wr_ptr;
        end else begin
            if (push) wr_ptr <= wr_ptr + CW'(1);
            if (pop)  rd_ptr <= rd_ptr + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush)
            mem[wr_ptr[AW-1:0]] <= wdata;
        else if (ovw)
            mem[newest] <= wdata;
    end

endmodule

// File: rtl/itc_park.sv
module itc_park #(
    parameter int NTHREADS = 4,
    parameter int DW       = 32,
    parameter int TID_W    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                q_full,
    input  logic                q_empty,
    input  logic                set,
    input  logic [TID_W-1:0]    set_tid,
    input  logic                set_we,
    input  logic [DW-1:0]       set_data,
    input  logic                take,
    output logic [NTHREADS-1:0] blocked,
    output logic                cand_valid,
    output logic [TID_W-1:0]    cand_tid,
    output logic                cand_we,
    output logic [DW-1:0]       cand_data
);

    logic                slot_we   [NTHREADS];
    logic [DW-1:0]       slot_data [NTHREADS];
    logic [NTHREADS-1:0] eligible;

    for (genvar g = 0; g < NTHREADS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                blocked[g] <= 1'b0;
            end else if (set && set_tid == TID_W'(g)) begin
                blocked[g] <= 1'b1;
            end else if (take && cand_tid == TID_W'(g)) begin
                blocked[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (set && set_tid == TID_W'(g)) begin
                slot_we[g]   <= set_we;
                slot_data[g] <= set_data;
            end
        end

        assign eligible[g] = blocked[g] & (slot_we[g] ? !q_full : !q_empty);
    end

    // lowest thread number wins
    always_comb begin
        cand_valid = 1'b0;
        cand_tid   = '0;
        for (int i = NTHREADS - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                cand_valid = 1'b1;
                cand_tid   = TID_W'(i);
            end
        end
    end

    assign cand_we   = slot_we[cand_tid];
    assign cand_data = slot_data[cand_tid];

endmodule

// File: rtl/itc_fifo_cell.sv
module itc_fifo_cell
    import itc_cell_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int NTHREADS = 4,
    localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
    localparam int CW      = $clog2(DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_view,
    input  logic [TID_W-1:0]    req_tid,
    input  logic                req_we,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic [TID_W-1:0]    rsp_tid,
    output logic [31:0]         rsp_rdata,
    output logic [NTHREADS-1:0] thr_ready
);

    view_e               view;
    logic [CW-1:0]       q_count;
    logic [CELL_DW-1:0]  q_head, q_wdata;
    logic                q_full, q_empty;
    logic                q_push, q_pop, q_ovw, q_flush;
    logic                pk_set, pk_take;
    logic [NTHREADS-1:0] pk_blocked;
    logic                pk_cand, pk_cand_we;
    logic [TID_W-1:0]    pk_cand_tid;
    logic [CELL_DW-1:0]  pk_cand_data;
    logic                nx_valid;
    logic [TID_W-1:0]    nx_tid;
    logic [CELL_DW-1:0]  nx_data;
    tag_t                tag;

    assign view    = view_e'(req_view);
    assign q_full  = (q_count == CW'(DEPTH));
    assign q_empty = (q_count == '0);
    assign tag     = make_tag(TAG_CNT_W'(q_count), q_full, q_empty);

    itc_ring #(.DEPTH(DEPTH), .DW(CELL_DW)) u_ring (
        .clk(clk), .rst(rst),
        .push(q_push), .pop(q_pop), .ovw(q_ovw), .flush(q_flush),
        .wdata(q_wdata), .head(q_head), .count(q_count)
    );

    itc_park #(.NTHREADS(NTHREADS), .DW(CELL_DW), .TID_W(TID_W)) u_park (
        .clk(clk), .rst(rst),
        .q_full(q_full), .q_empty(q_empty),
        .set(pk_set), .set_tid(req_tid), .set_we(req_we), .set_data(req_wdata),
        .take(pk_take), .blocked(pk_blocked),
        .cand_valid(pk_cand), .cand_tid(pk_cand_tid),
        .cand_we(pk_cand_we), .cand_data(pk_cand_data)
    );

    always_comb begin
        q_push   = 1'b0;
        q_pop    = 1'b0;
        q_ovw    = 1'b0;
        q_flush  = 1'b0;
        q_wdata  = req_wdata;
        pk_set   = 1'b0;
        pk_take  = 1'b0;
        nx_valid = 1'b0;
        nx_tid   = req_tid;
        nx_data  = '0;
        if (req_valid) begin
            unique case (view)
                VIEW_SYNC: begin
                    if (req_we) begin
                        if (q_full) pk_set = 1'b1;
                        else begin
                            q_push   = 1'b1;
                            nx_valid = 1'b1;
                        end
                    end else begin
                        if (q_empty) pk_set = 1'b1;
                        else begin
                            q_pop    = 1'b1;
                            nx_valid = 1'b1;
                            nx_data  = q_head;
                        end
                    end
                end
                VIEW_TRY: begin
                    nx_valid = 1'b1;
                    if (req_we) q_push = !q_full;
                    else begin
                        q_pop   = !q_empty;
                        nx_data = q_empty ? '0 : q_head;
                    end
                end
                VIEW_BYPASS: begin
                    nx_valid = 1'b1;
                    if (req_we) q_ovw = !q_empty;
                    else nx_data = q_empty ? '0 : q_head;
                end
                VIEW_CTRL: begin
                    nx_valid = 1'b1;
                    if (req_we) q_flush = req_wdata[FLUSH_BIT];
                    else nx_data = tag;
                end
            endcase
        end else if (pk_cand) begin
            pk_take  = 1'b1;
            nx_valid = 1'b1;
            nx_tid   = pk_cand_tid;
            if (pk_cand_we) begin
                q_push  = 1'b1;
                q_wdata = pk_cand_data;
            end else begin
                q_pop   = 1'b1;
                nx_data = q_head;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_tid   <= '0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= nx_valid;
            rsp_tid   <= nx_tid;
            rsp_rdata <= nx_data;
        end
    end

    assign thr_ready = ~pk_blocked;

endmodule

// File: rtl/itc_fifo_cell_chk.sv
module itc_fifo_cell_chk #(
    parameter int DEPTH    = 4,
    parameter int NTHREADS = 4,
    localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
    localparam int CW      = $clog2(DEPTH) + 1
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [1:0]          req_view,
    input logic [TID_W-1:0]    req_tid,
    input logic                req_we,
    input logic                flush_bit,
    input logic                rsp_valid,
    input logic [TID_W-1:0]    rsp_tid,
    input logic [NTHREADS-1:0] thr_ready,
    input logic [CW-1:0]       q_count
);

    logic would_park;
    assign would_park = (req_view == 2'd0) &&
                        (req_we ? (q_count == CW'(DEPTH)) : (q_count == '0));

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
        q_count <= CW'(DEPTH));

    assert_sync_push_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_view == 2'd0 && req_we && q_count != CW'(DEPTH)
        |=> q_count == $past(q_count) + CW'(1));

    assert_no_req_parked_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> thr_ready[req_tid]);

    assert_park_silent_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid && would_park |=> !rsp_valid && !thr_ready[$past(req_tid)]);

    for (genvar g = 0; g < NTHREADS; g++) begin : g_wake
        assert_wake_resp_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(thr_ready[g]) |-> rsp_valid && rsp_tid == TID_W'(g));
    end

    assert_try_full_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_view == 2'd1 && req_we && q_count == CW'(DEPTH)
        |=> q_count == CW'(DEPTH));

    assert_bypass_stable_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_view == 2'd2 |=> $stable(q_count));

    assert_flush_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_view == 2'd3 && req_we && flush_bit |=> q_count == '0);

    assert_rsp_next_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid && !would_park |=> rsp_valid && rsp_tid == $past(req_tid));

endmodule

bind itc_fifo_cell itc_fifo_cell_chk #(.DEPTH(DEPTH), .NTHREADS(NTHREADS)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_view(req_view),
    .req_tid(req_tid), .req_we(req_we), .flush_bit(req_wdata[0]),
    .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .thr_ready(thr_ready),
    .q_count(q_count)
);

// File: tb/itc_fifo_cell_test.sv
`timescale 1ns/1ps
module itc_fifo_cell_test;

    localparam int D  = 4;
    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_view = 2'd0;
    logic [1:0]    req_tid = 2'd0;
    logic          req_we = 1'b0;
    logic [31:0]   req_wdata = 32'd0;
    logic          rsp_valid;
    logic [1:0]    rsp_tid;
    logic [31:0]   rsp_rdata;
    logic [NT-1:0] thr_ready;

    always #2.5 clk = ~clk;

    itc_fifo_cell #(.DEPTH(D), .NTHREADS(NT)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_view(req_view),
        .req_tid(req_tid), .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_rdata(rsp_rdata),
        .thr_ready(thr_ready)
    );

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    // reference model
    logic [31:0] mq [D];
    int          mcnt;
    bit          mblk [NT];
    bit          mwe  [NT];
    logic [31:0] mdat [NT];
    bit          e_rv;
    int          e_tid;
    logic [31:0] e_data;

    task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mcnt = 0;
        for (int i = 0; i < NT; i++) mblk[i] = 0;
    endtask

    task automatic model_pop(output logic [31:0] v);
        v = mq[0];
        for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
        mcnt--;
    endtask

    function automatic logic [31:0] model_tag();
        return (32'(mcnt) << 8) | 32'h4 | ((mcnt == D) ? 32'h2 : 32'h0) |
               ((mcnt == 0) ? 32'h1 : 32'h0);
    endfunction

    task automatic model_step(bit v, int view, int t, bit we, logic [31:0] d);
        e_rv = 0; e_tid = t; e_data = 0;
        if (v) begin
            case (view)
                0: begin
                    if (we) begin
                        if (mcnt == D) begin mblk[t] = 1; mwe[t] = 1; mdat[t] = d; end
                        else begin mq[mcnt] = d; mcnt++; e_rv = 1; end
                    end else begin
                        if (mcnt == 0) begin mblk[t] = 1; mwe[t] = 0; end
                        else begin model_pop(e_data); e_rv = 1; end
                    end
                end
                1: begin
                    e_rv = 1;
                    if (we) begin if (mcnt < D) begin mq[mcnt] = d; mcnt++; end end
                    else if (mcnt > 0) model_pop(e_data);
                end
                2: begin
                    e_rv = 1;
                    if (we) begin if (mcnt > 0) mq[mcnt-1] = d; end
                    else e_data = (mcnt > 0) ? mq[0] : 32'd0;
                end
                default: begin
                    e_rv = 1;
                    if (we) begin if (d[0]) mcnt = 0; end
                    else e_data = model_tag();
                end
            endcase
        end else begin
            for (int i = 0; i < NT; i++) begin
                if (!e_rv && mblk[i] && (mwe[i] ? (mcnt < D) : (mcnt > 0))) begin
                    e_rv = 1; e_tid = i; mblk[i] = 0;
                    if (mwe[i]) begin mq[mcnt] = mdat[i]; mcnt++; end
                    else model_pop(e_data);
                end
            end
        end
    endtask

    task automatic check_outputs(string r);
        logic [NT-1:0] er;
        for (int i = 0; i < NT; i++) er[i] = !mblk[i];
        chk(r, "rsp_valid", 32'(rsp_valid), 32'(e_rv));
        if (e_rv) begin
            chk(r, "rsp_tid", 32'(rsp_tid), 32'(e_tid));
            chk(r, "rsp_rdata", rsp_rdata, e_data);
        end
        chk(r, "thr_ready", 32'(thr_ready), 32'(er));
    endtask

    task automatic step(string r, bit v, int view, int t, bit we, logic [31:0] d);
        @(negedge clk);
        req_valid = v; req_view = 2'(view); req_tid = 2'(t);
        req_we = we; req_wdata = d;
        model_step(v, view, t, we, d);
        @(posedge clk); #1;
        check_outputs(r);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; req_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        e_rv = 0;
        check_outputs("R9");
        step("R9", 1, 3, 0, 0, 0);
    endtask

    function automatic string tag_of(bit v, int view, bit we);
        if (!v) return "R3";
        case (view)
            0: return "R1";
            1: return "R4";
            2: return we ? "R6" : "R5";
            default: return we ? "R8" : "R7";
        endcase
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // fill and order
        step("R10", 1, 0, 0, 1, 32'hA1);
        step("R1", 1, 0, 0, 1, 32'hA2);
        step("R1", 1, 0, 0, 1, 32'hA3);
        step("R1", 1, 0, 0, 1, 32'hA4);
        step("R7", 1, 3, 2, 0, 0);
        step("R4", 1, 1, 0, 1, 32'hDEAD);
        step("R5", 1, 2, 3, 0, 0);
        step("R6", 1, 2, 1, 1, 32'hB0);
        // park a store on full, wake after pop
        step("R2", 1, 0, 1, 1, 32'hC0);
        step("R3", 0, 0, 0, 0, 0);
        step("R1", 1, 0, 0, 0, 0);
        step("R3", 0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) step("R1", 1, 0, 0, 0, 0);
        // empty corner cases
        step("R4", 1, 1, 2, 0, 0);
        step("R5", 1, 2, 2, 0, 0);
        step("R6", 1, 2, 2, 1, 32'h55);
        step("R7", 1, 3, 2, 0, 0);
        // two parked loads, lowest thread first
        step("R2", 1, 0, 3, 0, 0);
        step("R2", 1, 0, 2, 0, 0);
        step("R8", 1, 3, 0, 1, 32'hFFFF_FFFE);
        step("R3", 0, 0, 0, 0, 0);
        step("R1", 1, 0, 0, 1, 32'hD0);
        step("R3", 0, 0, 0, 0, 0);
        step("R3", 0, 0, 0, 0, 0);
        step("R1", 1, 0, 0, 1, 32'hE0);
        step("R3", 0, 0, 0, 0, 0);
        // flush
        step("R1", 1, 0, 1, 1, 32'h1);
        step("R1", 1, 0, 1, 1, 32'h2);
        step("R1", 1, 0, 1, 1, 32'h3);
        step("R8", 1, 3, 1, 1, 32'h1);
        step("R8", 1, 3, 1, 0, 0);
        step("R4", 1, 1, 1, 0, 0);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            bit v;
            int view, t, cnt_rdy;
            bit we;
            logic [31:0] d;
            v = ($urandom % 4) != 0;
            view = $urandom % 4;
            we = $urandom % 2;
            d = $urandom;
            cnt_rdy = 0;
            for (int i = 0; i < NT; i++) if (!mblk[i]) cnt_rdy++;
            if (cnt_rdy == 0) begin
                do_reset();
            end else begin
                t = $urandom % NT;
                while (mblk[t]) t = (t + 1) % NT;
                step(tag_of(v, view, we), v, view, t, we, d);
            end
        end
        finished = 1;
        summary();
        $finish;
    end

endmodule